// File: doc/BRIEF.md
# Compare Timer Frame with Auto-Increment

This block is one timer frame that watches a shared, free-running 64-bit system count supplied on an input port. Software programs a 64-bit compare value and enables the frame. Once the count has reached that value, a read-only status bit goes high. A level interrupt is raised unless the mask bit is set. The count and the compare value are both visible as pairs of 32-bit halves on a simple register bus. The bus has a write strobe and a combinational read path.

An auto-increment mode gives periodic interrupts without software re-arming. Each time the count reaches the compare value, hardware adds a programmed 32-bit interval to the compare value and sets an event flag. The status bit, and with it the interrupt, stays high until software clears that flag by writing 0 to it. A read-only feature register reports whether the auto-increment hardware is present.

The count halves are read live. Software must read the high half, then the low half, then the high half again, and retry if the two high reads differ. The asynchronous reset input is released to the internal registers through a two-stage synchronizer.

Top module: `cmp_timer_frame`

## Requirements
- R1: After reset, control, both compare halves, the interval register and the auto-increment control all read 0, and `irq` is 0.
- R2: Offset 0x00 reads bits [31:0] of `sys_count` and offset 0x04 reads bits [63:32], both live. Writes to these offsets change no state, and the halves still follow the input.
- R3: A write to offset 0x20 (low half) or 0x24 (high half) replaces that half of the compare value on the next clock edge and reads back unchanged.
- R4: Control at offset 0x2C has these bits: bit 0 enable (read/write), bit 1 mask (read/write), bit 2 status (read-only). Other bits read 0. Status is 0 while enable is 0.
- R5: `irq` is 1 exactly when enable is 1, mask is 0 and status is 1.
- R6: Auto-increment control at offset 0x4C has bit 0 as the mode enable (read/write). The interval register at offset 0x48 is a 32-bit read/write register.
- R7: When enable, the mode enable and the compare condition all hold at a clock edge, the compare value becomes compare plus the zero-extended interval (carrying into the high half) and the event flag (bit 1 of 0x4C) is set.
- R8: Writing 0 to bit 1 of 0x4C clears the event flag and writing 1 leaves it unchanged. A hardware event in the same cycle as a clearing write leaves the flag set.
- R9: While enable is 1 and the event flag is set, status reads 1 even after the compare value has moved ahead of the count.
- R10: Offset 0x50 reads 1 in bits [3:0] (auto-increment present) and 0 elsewhere, and writes to it are ignored. Unmapped offsets read 0.
- R11: A software write to either compare half in the same cycle as an auto-increment event wins: the written value is stored, no increment is applied and the flag is not set.
- R12: The compare condition is that count minus compare, taken as a signed 64-bit value, is not negative. A compare value more than 2^63 above the count therefore counts as reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_count | input | 64 | Free-running count from the shared system counter |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A wrong compare register or a lost carry shows up as an interrupt that fires at the wrong count. It is visible on `irq` and in the compare readback one edge after the event. A stuck or wrongly cleared event flag shows at once in the status bit and on `irq`, because both are combinational from the flag. A sign error in the comparison is invisible until the count and the compare value lie more than 2^63 apart, so the bench drives the count directly to reach that case. A write-priority error between software and the hardware increment shows only when both land on the same edge, so the bench aligns them deliberately.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CMP_LO = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CMP_HI = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_CTL    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_STEP   = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_AICTL  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_FEAT   = 8'h50;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int AI_EN_BIT    = 0;
  localparam int AI_FLAG_BIT  = 1;

  localparam logic [3:0] FEAT_AI_CODE = 4'd1;

  typedef struct packed {
    logic cmp_lo;
    logic cmp_hi;
    logic ctl;
    logic step;
    logic aictl;
  } wr_strobe_t;
endpackage

// File: rtl/cmpt_decode.sv
module cmpt_decode
  import cmpt_pkg::*;
(
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_strobe_t        strb
);
  always_comb begin
    strb.cmp_lo = bus_wr && (bus_addr == OFF_CMP_LO);
    strb.cmp_hi = bus_wr && (bus_addr == OFF_CMP_HI);
    strb.ctl    = bus_wr && (bus_addr == OFF_CTL);
    strb.step   = bus_wr && (bus_addr == OFF_STEP);
    strb.aictl  = bus_wr && (bus_addr == OFF_AICTL);
  end
endmodule

// File: rtl/cmpt_match.sv
module cmpt_match #(
  parameter int CNT_W = 64
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp,
  output logic             met
);
  logic [CNT_W-1:0] diff;

  always_comb begin
    diff = count - cmp;
    met  = ~diff[CNT_W-1];
  end
endmodule

// File: rtl/cmpt_state.sv
module cmpt_state
  import cmpt_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter bit AI_IMPL = 1'b1,
  localparam int CNT_W  = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strobe_t       strb,
  input  logic [BUS_W-1:0] wdata,
  input  logic             met,
  output logic             ctl_en,
  output logic             ctl_mask,
  output logic [CNT_W-1:0] cmp_q,
  output logic             ai_en,
  output logic             ai_flag,
  output logic [BUS_W-1:0] step_q,
  output logic             fire
);
  logic             cmp_ld;
  logic [CNT_W-1:0] cmp_nxt;
  logic             sw_cmp;

  assign sw_cmp = strb.cmp_lo | strb.cmp_hi;

  always_comb begin
    cmp_nxt = cmp_q;
    if (strb.cmp_lo) cmp_nxt[BUS_W-1:0]     = wdata;
    if (strb.cmp_hi) cmp_nxt[CNT_W-1:BUS_W] = wdata;
    if (fire)        cmp_nxt = cmp_q + {{BUS_W{1'b0}}, step_q};
    cmp_ld = sw_cmp | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_ld) begin
      cmp_q <= cmp_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_mask <= 1'b0;
    end else if (strb.ctl) begin
      ctl_en   <= wdata[CTL_EN_BIT];
      ctl_mask <= wdata[CTL_MASK_BIT];
    end
  end

  generate
    if (AI_IMPL) begin : g_ai
      logic flag_nxt;

      always_comb begin
        fire     = ctl_en & ai_en & met & ~sw_cmp;
        flag_nxt = ai_flag;
        if (strb.aictl && !wdata[AI_FLAG_BIT]) flag_nxt = 1'b0;
        if (fire)                              flag_nxt = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          step_q <= '0;
        end else if (strb.step) begin
          step_q <= wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ai_en <= 1'b0;
        end else if (strb.aictl) begin
          ai_en <= wdata[AI_EN_BIT];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ai_flag <= 1'b0;
        end else begin
          ai_flag <= flag_nxt;
        end
      end
    end else begin : g_no_ai
      assign fire    = 1'b0;
      assign step_q  = '0;
      assign ai_en   = 1'b0;
      assign ai_flag = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cmpt_rdmux.sv
module cmpt_rdmux
  import cmpt_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter bit AI_IMPL = 1'b1,
  localparam int CNT_W  = 2 * BUS_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  cmp,
  input  logic              ctl_en,
  input  logic              ctl_mask,
  input  logic              status,
  input  logic [BUS_W-1:0]  step,
  input  logic              ai_en,
  input  logic              ai_flag,
  output logic [BUS_W-1:0]  rdata
);
  localparam logic [3:0] FEAT = AI_IMPL ? FEAT_AI_CODE : 4'd0;

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CNT_LO: rdata = count[BUS_W-1:0];
      OFF_CNT_HI: rdata = count[CNT_W-1:BUS_W];
      OFF_CMP_LO: rdata = cmp[BUS_W-1:0];
      OFF_CMP_HI: rdata = cmp[CNT_W-1:BUS_W];
      OFF_CTL:    rdata = BUS_W'({status, ctl_mask, ctl_en});
      OFF_STEP:   rdata = step;
      OFF_AICTL:  rdata = BUS_W'({ai_flag, ai_en});
      OFF_FEAT:   rdata = BUS_W'(FEAT);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmp_timer_frame.sv
module cmp_timer_frame
  import cmpt_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter bit AI_IMPL = 1'b1,
  localparam int CNT_W  = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [1:0]       rst_sync;
  logic             rst_i_n;
  wr_strobe_t       strb;
  logic             met;
  logic             status;
  logic             ctl_en;
  logic             ctl_mask;
  logic [CNT_W-1:0] cmp_q;
  logic             ai_en;
  logic             ai_flag;
  logic [BUS_W-1:0] step_q;
  logic             fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync[1];

  cmpt_decode u_dec (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .strb    (strb)
  );

  cmpt_match #(.CNT_W(CNT_W)) u_match (
    .count(sys_count),
    .cmp  (cmp_q),
    .met  (met)
  );

  cmpt_state #(.BUS_W(BUS_W), .AI_IMPL(AI_IMPL)) u_state (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .strb    (strb),
    .wdata   (bus_wdata),
    .met     (met),
    .ctl_en  (ctl_en),
    .ctl_mask(ctl_mask),
    .cmp_q   (cmp_q),
    .ai_en   (ai_en),
    .ai_flag (ai_flag),
    .step_q  (step_q),
    .fire    (fire)
  );

  assign status = ctl_en & (met | ai_flag);
  assign irq    = status & ~ctl_mask;

  cmpt_rdmux #(.BUS_W(BUS_W), .AI_IMPL(AI_IMPL)) u_rd (
    .addr    (bus_addr),
    .count   (sys_count),
    .cmp     (cmp_q),
    .ctl_en  (ctl_en),
    .ctl_mask(ctl_mask),
    .status  (status),
    .step    (step_q),
    .ai_en   (ai_en),
    .ai_flag (ai_flag),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/cmpt_checker.sv
module cmpt_checker
  import cmpt_pkg::*;
#(
  parameter int BUS_W  = 32,
  localparam int CNT_W = 2 * BUS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              irq,
  input logic              ctl_en,
  input logic              ctl_mask,
  input logic              status,
  input logic [CNT_W-1:0]  cmp,
  input logic [BUS_W-1:0]  step,
  input logic              ai_flag,
  input logic              fire
);
  // R4: a disabled frame never reports status
  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !status);

  // R5: a masked frame never drives the interrupt
  p_masked_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mask |-> !irq);

  // R3: low compare half takes the written word one edge later
  p_cmp_lo_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CMP_LO) |=> cmp[BUS_W-1:0] == $past(bus_wdata));

  // R7: an event steps the compare value by the interval and raises the flag
  p_autoinc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cmp == $past(cmp) + {{BUS_W{1'b0}}, $past(step)}) && ai_flag);

  // R8: the flag survives unless a clearing write arrives
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ai_flag && !(bus_wr && bus_addr == OFF_AICTL && !bus_wdata[AI_FLAG_BIT]))
      |=> ai_flag);

  // R9: a pending event keeps status high while enabled
  p_flag_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && ai_flag) |-> status);

  // R10: writes to read-only offsets leave all writable state untouched
  p_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !fire && (bus_addr == OFF_FEAT || bus_addr == OFF_CNT_LO ||
                         bus_addr == OFF_CNT_HI))
      |=> $stable(cmp) && $stable(step) && $stable(ctl_en) && $stable(ctl_mask));
endmodule

bind cmp_timer_frame cmpt_checker #(.BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq      (irq),
  .ctl_en   (ctl_en),
  .ctl_mask (ctl_mask),
  .status   (status),
  .cmp      (cmp_q),
  .step     (step_q),
  .ai_flag  (ai_flag),
  .fire     (fire)
);

// File: tb/sim_cmp_timer_frame.sv
module sim_cmp_timer_frame;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] sys_count;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_timer_frame u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_count(sys_count),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  // {offset, write data, expected readback}
  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {8'h20, 32'hDEADBEEF, 32'hDEADBEEF},  // R3 low half
    {8'h24, 32'h12345678, 32'h12345678},  // R3 high half
    {8'h48, 32'hCAFEF00D, 32'hCAFEF00D},  // R6 interval
    {8'h2C, 32'hFFFFFFFA, 32'h00000002},  // R4 only mask, status read-only
    {8'h2C, 32'h00000000, 32'h00000000},  // R4
    {8'h4C, 32'hFFFFFFFE, 32'h00000000},  // R8 writing flag 1 has no effect
    {8'h50, 32'h00000000, 32'h00000001},  // R10 feature read-only
    {8'h60, 32'hFFFFFFFF, 32'h00000000}   // R10 unmapped
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; sys_count = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h2C, r); chk("R1 ctl", r, 0);
    rd(8'h20, r); chk("R1 cmp lo", r, 0);
    rd(8'h24, r); chk("R1 cmp hi", r, 0);
    rd(8'h48, r); chk("R1 interval", r, 0);
    rd(8'h4C, r); chk("R1 aictl", r, 0);
    chk("R1 irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], r);
      chk($sformatf("vector %0d (R3 R4 R6 R8 R10)", i), r, VEC[i][31:0]);
    end

    // R2 live count halves, writes ignored
    sys_count = 64'h01234567_89ABCDEF;
    rd(8'h00, r); chk("R2 count lo", r, 32'h89ABCDEF);
    rd(8'h04, r); chk("R2 count hi", r, 32'h01234567);
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h04, 32'h0);
    rd(8'h00, r); chk("R2 count lo after write", r, 32'h89ABCDEF);
    rd(8'h20, r); chk("R2 cmp untouched", r, 32'hDEADBEEF);
    sys_count = 64'hFEDCBA98_00000007;
    rd(8'h04, r); chk("R2 count hi follows", r, 32'hFEDCBA98);
    rd(8'h50, r); chk("R10 feature after writes", r, 1);

    // R4 / R12 compare condition
    sys_count = 64'd100;
    wr(8'h24, 0); wr(8'h20, 100);
    rd(8'h2C, r); chk("R4 disabled status", r, 0);
    wr(8'h2C, 1);
    rd(8'h2C, r); chk("R4 equal met", r, 5);
    chk("R5 irq on", irq, 1);
    sys_count = 64'd99;
    rd(8'h2C, r); chk("R4 one below", r, 1);
    chk("R5 irq off", irq, 0);
    sys_count = 64'h10;
    wr(8'h24, 32'h80000000); wr(8'h20, 32'h20);
    rd(8'h2C, r); chk("R12 far ahead counts as met", r, 5);
    wr(8'h24, 32'h7FFFFFFF);
    rd(8'h2C, r); chk("R12 within half range not met", r, 1);

    // R5 masking
    wr(8'h24, 0); wr(8'h20, 5);
    wr(8'h2C, 3);
    rd(8'h2C, r); chk("R5 masked status stays", r, 7);
    chk("R5 masked irq", irq, 0);
    wr(8'h2C, 2);
    chk("R5 disabled irq", irq, 0);

    // R7 / R9 auto-increment
    sys_count = 64'd100;
    wr(8'h20, 100); wr(8'h48, 50); wr(8'h2C, 1); wr(8'h4C, 1);
    @(negedge clk);
    rd(8'h20, r); chk("R7 stepped compare", r, 150);
    rd(8'h4C, r); chk("R7 flag set", r, 3);
    rd(8'h2C, r); chk("R9 status held", r, 5);
    chk("R9 irq held", irq, 1);
    wr(8'h4C, 1);
    rd(8'h4C, r); chk("R8 flag cleared", r, 1);
    rd(8'h2C, r); chk("R9 status drops", r, 1);
    chk("R9 irq drops", irq, 0);

    // R8 hardware set beats clearing write
    @(negedge clk);
    sys_count = 64'd150; bus_wr = 1'b1; bus_addr = 8'h4C; bus_wdata = 32'h1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(8'h4C, r); chk("R8 set wins", r, 3);
    rd(8'h20, r); chk("R7 second step", r, 200);

    // R11 software compare write beats the event
    wr(8'h4C, 1);
    @(negedge clk);
    sys_count = 64'd200; bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'd1000;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(8'h20, r); chk("R11 written value kept", r, 1000);
    rd(8'h4C, r); chk("R11 no flag", r, 1);

    // R7 zero-extended interval carries into high half
    wr(8'h48, 32'hFFFFFFFF);
    sys_count = 64'd1000;
    @(negedge clk);
    rd(8'h24, r); chk("R7 carry hi", r, 1);
    rd(8'h20, r); chk("R7 carry lo", r, 32'h3E7);

    done = 1'b1;
    finish_run();
  end
endmodule